// File: doc/BRIEF.md
# Flag-Setting Bitwise Logic Unit

This datapath slice performs one of five bitwise operations on a 32-bit first operand and a second operand produced by a small shift stage. The shift stage can move the second operand left or right, do a sign-extending right shift or rotate it, by 0 to 31 places. It also produces the last bit shifted out as a carry. The result is combinational. When the caller asks for it, a registered flag set (negative, zero, carry, overflow) is updated on the next clock edge.

The caller supplies the register indices of the destination and the first operand. The unit rejects the stack pointer (index 13) and the program counter (index 15) in either position, and it rejects operation codes outside the five defined ones. A rejected request raises `invalid` and writes nothing. A low condition-pass input also blocks the write and the flag update, but the result is still driven.

Top module: `bitlogic_flag_unit`

## Requirements
- R1: With `op_sel` 000 the result is first operand AND second operand. With 001 it is their exclusive-OR. With 010 it is their OR.
- R2: With `op_sel` 011 the result is first operand AND the complement of the second operand. With 100 it is first operand OR the complement of the second operand.
- R3: `op_sel` codes 101, 110 and 111 are reserved. They raise `invalid`, hold `wr_en` low, drive a zero result and leave all flags unchanged.
- R4: A `dest_idx` or `src_a_idx` of 13 or 15 raises `invalid`, holds `wr_en` low and leaves all flags unchanged.
- R5: `shift_kind` selects how the second operand is formed from `src_val` by `shift_amt` places (0 to 31): 00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right. An amount of 0 passes `src_val` through unchanged.
- R6: The flags change only on a rising clock edge where `set_flags` and `cond_pass` are both 1 and `invalid` is 0. On every other edge all four flags keep their values.
- R7: On an update, `flag_n` takes result bit 31, and `flag_z` is 1 exactly when the result is all zeros.
- R8: On an update with a nonzero `shift_amt`, `flag_c` takes the last bit shifted out of `src_val`: bit 32-n for a left shift by n, and bit n-1 for the other three kinds. With a zero amount `flag_c` keeps its value.
- R9: `flag_v` is never modified by any operation, so it stays at its reset value of 0.
- R10: With `cond_pass` low, `wr_en` is 0 and no flag changes. The result is still driven.
- R11: A synchronous active-high `rst` clears all four flags at the clock edge.
- R12: `wr_en` is 1 exactly when `cond_pass` is 1 and `invalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_sel | input | 3 | Operation code |
| dest_idx | input | 4 | Destination register index |
| src_a_idx | input | 4 | First-operand register index |
| op_a | input | 32 | First operand value |
| src_val | input | 32 | Second operand before shifting |
| shift_kind | input | 2 | Shift type for the second operand |
| shift_amt | input | 5 | Shift amount, 0 to 31 |
| set_flags | input | 1 | Request a flag update |
| cond_pass | input | 1 | Condition met; low suppresses the write and the flag update |
| result | output | 32 | Combinational operation result |
| wr_en | output | 1 | Result write enable |
| invalid | output | 1 | Reserved code or forbidden register index |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The flags are the only state in this block. A wrong flag register therefore shows at the flag ports one clock edge after the operation that caused it, and it keeps showing there until the next legal update. The bench checks the flags right after each operation, so a stale or wrongly captured value is seen within one cycle. The bench also checks that a zero-amount shift reuses the held carry. This means a bad carry register also shows in the carry of the following operation. Faults in the result, `wr_en` or `invalid` have no state behind them and show in the same cycle as the inputs that cause them.

// File: rtl/bitlogic_flag_unit.sv
module bitlogic_flag_unit #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int SP_IDX = 13,
  parameter int PC_IDX = 15
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [2:0]                op_sel,
  input  logic [IDX_W-1:0]          dest_idx,
  input  logic [IDX_W-1:0]          src_a_idx,
  input  logic [DATA_W-1:0]         op_a,
  input  logic [DATA_W-1:0]         src_val,
  input  logic [1:0]                shift_kind,
  input  logic [$clog2(DATA_W)-1:0] shift_amt,
  input  logic                      set_flags,
  input  logic                      cond_pass,
  output logic [DATA_W-1:0]         result,
  output logic                      wr_en,
  output logic                      invalid,
  output logic                      flag_n,
  output logic                      flag_z,
  output logic                      flag_c,
  output logic                      flag_v
);
  localparam int SH_W = $clog2(DATA_W);

  localparam logic [2:0] OP_AND = 3'd0;
  localparam logic [2:0] OP_XOR = 3'd1;
  localparam logic [2:0] OP_OR  = 3'd2;
  localparam logic [2:0] OP_CLR = 3'd3;
  localparam logic [2:0] OP_ORN = 3'd4;

  localparam logic [1:0] SH_LSL = 2'd0;
  localparam logic [1:0] SH_LSR = 2'd1;
  localparam logic [1:0] SH_ASR = 2'd2;
  localparam logic [1:0] SH_ROR = 2'd3;

  localparam logic [IDX_W-1:0] SP_CODE = IDX_W'(SP_IDX);
  localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);

  logic [SH_W-1:0]   lsl_pos;
  logic [SH_W-1:0]   rsh_pos;
  logic [DATA_W-1:0] op_b;
  logic              sh_carry;
  logic              bad_op;
  logic              bad_idx;
  logic              upd;

  assign lsl_pos = ~shift_amt + 1'b1;
  assign rsh_pos = shift_amt - 1'b1;

  always_comb begin
    op_b     = src_val;
    sh_carry = flag_c;
    if (shift_amt != '0) begin
      case (shift_kind)
        SH_LSL: begin
          op_b     = src_val << shift_amt;
          sh_carry = src_val[lsl_pos];
        end
        SH_LSR: begin
          op_b     = src_val >> shift_amt;
          sh_carry = src_val[rsh_pos];
        end
        SH_ASR: begin
          op_b     = DATA_W'($signed(src_val) >>> shift_amt);
          sh_carry = src_val[rsh_pos];
        end
        SH_ROR: begin
          op_b     = (src_val >> shift_amt) | (src_val << lsl_pos);
          sh_carry = src_val[rsh_pos];
        end
        default: begin
          op_b     = src_val;
          sh_carry = flag_c;
        end
      endcase
    end
  end

  always_comb begin
    case (op_sel)
      OP_AND:  result = op_a & op_b;
      OP_XOR:  result = op_a ^ op_b;
      OP_OR:   result = op_a | op_b;
      OP_CLR:  result = op_a & ~op_b;
      OP_ORN:  result = op_a | ~op_b;
      default: result = '0;
    endcase
  end

  assign bad_op  = op_sel > OP_ORN;
  assign bad_idx = (dest_idx == SP_CODE) || (dest_idx == PC_CODE) ||
                   (src_a_idx == SP_CODE) || (src_a_idx == PC_CODE);
  assign invalid = bad_op || bad_idx;
  assign wr_en   = cond_pass && !invalid;
  assign upd     = wr_en && set_flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else if (upd) begin
      flag_n <= result[DATA_W-1];
      flag_z <= ~|result;
      flag_c <= sh_carry;
    end
  end
endmodule

// File: rtl/bitlogic_flag_unit_chk.sv
module bitlogic_flag_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [2:0]                op_sel,
  input logic [IDX_W-1:0]          dest_idx,
  input logic [IDX_W-1:0]          src_a_idx,
  input logic [$clog2(DATA_W)-1:0] shift_amt,
  input logic                      set_flags,
  input logic                      cond_pass,
  input logic [DATA_W-1:0]         result,
  input logic                      wr_en,
  input logic                      invalid,
  input logic                      flag_n,
  input logic                      flag_z,
  input logic                      flag_c,
  input logic                      flag_v
);
  logic take;
  assign take = set_flags && cond_pass && !invalid;

  assert_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 3'd4) |-> (invalid && !wr_en && result == '0));

  assert_sp_pc_R4: assert property (@(posedge clk) disable iff (rst)
    (dest_idx == 13 || dest_idx == 15 || src_a_idx == 13 || src_a_idx == 15)
      |-> (invalid && !wr_en));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  assert_n_follows_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> (flag_n == $past(result[DATA_W-1])));

  assert_z_follows_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> (flag_z == ($past(result) == '0)));

  assert_zero_shift_c_R8: assert property (@(posedge clk) disable iff (rst)
    (take && shift_amt == '0) |=> $stable(flag_c));

  assert_v_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    !flag_v);

  assert_cond_block_R10: assert property (@(posedge clk) disable iff (rst)
    !cond_pass |-> !wr_en);
endmodule

bind bitlogic_flag_unit bitlogic_flag_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .dest_idx(dest_idx), .src_a_idx(src_a_idx),
  .shift_amt(shift_amt), .set_flags(set_flags), .cond_pass(cond_pass),
  .result(result), .wr_en(wr_en), .invalid(invalid),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/bitlogic_flag_unit_bench.sv
module bitlogic_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op_sel;
  logic [3:0]  dest_idx, src_a_idx;
  logic [31:0] op_a, src_val, result;
  logic [1:0]  shift_kind;
  logic [4:0]  shift_amt;
  logic        set_flags, cond_pass, wr_en, invalid;
  logic        flag_n, flag_z, flag_c, flag_v;

  int n_chk = 0;
  int n_bad = 0;
  logic en, ez, ec, ev;

  always #4 clk = ~clk;

  bitlogic_flag_unit u_bitlogic_flag_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .dest_idx(dest_idx), .src_a_idx(src_a_idx),
    .op_a(op_a), .src_val(src_val), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .set_flags(set_flags), .cond_pass(cond_pass), .result(result), .wr_en(wr_en),
    .invalid(invalid), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] ref_b(input logic [1:0] k, input logic [4:0] n,
                                        input logic [31:0] v, input logic cin);
    logic c = cin;
    for (int i = 0; i < int'(n); i++) begin
      case (k)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic run(input string req, input logic [2:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [1:0] k, input logic [4:0] n,
                     input logic sf, input logic cp, input logic [3:0] rd, input logic [3:0] rn);
    logic [32:0] sb;
    logic [31:0] er;
    logic bad, upd;
    @(negedge clk);
    op_sel = op; op_a = a; src_val = b; shift_kind = k; shift_amt = n;
    set_flags = sf; cond_pass = cp; dest_idx = rd; src_a_idx = rn;
    sb = ref_b(k, n, b, ec);
    case (op)
      3'd0: er = a & sb[31:0];
      3'd1: er = a ^ sb[31:0];
      3'd2: er = a | sb[31:0];
      3'd3: er = a & ~sb[31:0];
      3'd4: er = a | ~sb[31:0];
      default: er = 32'h0;
    endcase
    bad = (op > 3'd4) || rd == 4'd13 || rd == 4'd15 || rn == 4'd13 || rn == 4'd15;
    #1;
    if (!(rd == 4'd13 || rd == 4'd15 || rn == 4'd13 || rn == 4'd15))
      chk({req, " result"}, result, er);
    chk({req, " invalid"}, {31'd0, invalid}, {31'd0, bad});
    chk({req, " wr_en R12"}, {31'd0, wr_en}, {31'd0, cp && !bad});
    upd = sf && cp && !bad;
    if (upd) begin en = er[31]; ez = (er == 32'h0); ec = sb[32]; end
    @(negedge clk);
    chk({req, " flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, en, ez, ec, ev});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    en = 0; ez = 0; ec = 0; ev = 0;
    chk("R11 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'h0);
  endtask

  task automatic t_basic();
    run("R1 and", 3'd0, 32'hF0F0_1234, 32'hFF00_FF00, 2'd0, 5'd0, 1'b0, 1'b1, 4'd1, 4'd2);
    run("R1 xor", 3'd1, 32'hAAAA_5555, 32'h0F0F_0F0F, 2'd0, 5'd0, 1'b0, 1'b1, 4'd3, 4'd4);
    run("R1 or",  3'd2, 32'h1200_0034, 32'h0056_7800, 2'd0, 5'd0, 1'b0, 1'b1, 4'd0, 4'd12);
    run("R2 clr", 3'd3, 32'hFFFF_FFFF, 32'h0000_F00F, 2'd0, 5'd0, 1'b0, 1'b1, 4'd5, 4'd6);
    run("R2 orn", 3'd4, 32'h0000_0001, 32'hFFFF_0000, 2'd0, 5'd0, 1'b0, 1'b1, 4'd7, 4'd8);
  endtask

  task automatic t_shifts();
    run("R5 R8 lsl", 3'd2, 32'h0, 32'h4000_0001, 2'd0, 5'd2, 1'b1, 1'b1, 4'd1, 4'd1);
    run("R5 R8 lsr", 3'd2, 32'h0, 32'h0000_0006, 2'd1, 5'd2, 1'b1, 1'b1, 4'd1, 4'd1);
    run("R5 R8 asr", 3'd2, 32'h0, 32'h8000_0010, 2'd2, 5'd4, 1'b1, 1'b1, 4'd1, 4'd1);
    run("R5 R8 ror", 3'd2, 32'h0, 32'h0000_0013, 2'd3, 5'd1, 1'b1, 1'b1, 4'd1, 4'd1);
    run("R5 R8 lsl31", 3'd0, 32'hFFFF_FFFF, 32'h0000_0003, 2'd0, 5'd31, 1'b1, 1'b1, 4'd2, 4'd2);
    run("R5 R8 ror31", 3'd1, 32'h1, 32'h8000_0001, 2'd3, 5'd31, 1'b1, 1'b1, 4'd2, 4'd2);
    run("R8 zero amt keeps c", 3'd0, 32'hFFFF_FFFF, 32'h0, 2'd1, 5'd0, 1'b1, 1'b1, 4'd2, 4'd2);
  endtask

  task automatic t_nz();
    run("R7 negative", 3'd2, 32'h8000_0000, 32'h1, 2'd0, 5'd0, 1'b1, 1'b1, 4'd9, 4'd10);
    run("R7 zero", 3'd3, 32'h1234_5678, 32'hFFFF_FFFF, 2'd0, 5'd0, 1'b1, 1'b1, 4'd9, 4'd10);
  endtask

  task automatic t_hold();
    run("R6 sf low", 3'd4, 32'h0, 32'h0, 2'd1, 5'd1, 1'b0, 1'b1, 4'd1, 4'd2);
    run("R10 cond low", 3'd2, 32'h8000_0000, 32'h0000_0001, 2'd1, 5'd1, 1'b1, 1'b0, 4'd1, 4'd2);
  endtask

  task automatic t_illegal();
    run("R3 op5", 3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 5'd1, 1'b1, 1'b1, 4'd1, 4'd2);
    run("R3 op7", 3'd7, 32'h8000_0000, 32'h1, 2'd1, 5'd1, 1'b1, 1'b1, 4'd1, 4'd2);
    run("R4 rd sp", 3'd2, 32'h8000_0000, 32'h1, 2'd1, 5'd1, 1'b1, 1'b1, 4'd13, 4'd2);
    run("R4 rd pc", 3'd2, 32'h0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 4'd15, 4'd2);
    run("R4 rn sp", 3'd2, 32'h0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 4'd3, 4'd13);
    run("R4 rn pc", 3'd0, 32'h0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 4'd3, 4'd15);
  endtask

  task automatic t_overflow();
    run("R9 v after orn", 3'd4, 32'h7FFF_FFFF, 32'h0, 2'd2, 5'd3, 1'b1, 1'b1, 4'd4, 4'd4);
    chk("R9 v stays zero", {31'd0, flag_v}, 32'h0);
  endtask

  task automatic t_reset_mid();
    run("R11 prep", 3'd2, 32'h8000_0000, 32'h0000_0001, 2'd1, 5'd1, 1'b1, 1'b1, 4'd1, 4'd1);
    do_reset();
  endtask

  bit done = 0;

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_sel = 3'd0; op_a = '0; src_val = '0; shift_kind = '0; shift_amt = '0;
    set_flags = 1'b0; cond_pass = 1'b0; dest_idx = 4'd0; src_a_idx = 4'd0;
    en = 0; ez = 0; ec = 0; ev = 0;
    do_reset();
    t_basic();
    t_shifts();
    t_nz();
    t_hold();
    t_illegal();
    t_overflow();
    t_reset_mid();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule